// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Bank

This block is the shared status and control register bank of a sixteen-channel DMA engine. Each channel engine reports three kinds of events as single-cycle pulses: a finished command, a terminated command, and a failed bus access. The bank records each event in a sticky status bit. It keeps one interrupt enable per channel for completion. It drives one interrupt line and one fault line per channel. It also holds a pause (freeze) bit and a self-clearing reset bit for every channel.

Software reaches the bank over a plain word-addressed register bus. Writes take effect on the clock edge. Read data is a combinational function of the address. Each of the three registers has three write views: a plain view, a set-only view and a clear-only view. With the last two, a driver can change single bits without a read-modify-write.

The error register splits each channel's error across its two half-words. A termination raises only the channel's flag in the low half. A bus error raises that flag and also the channel's status bit in the high half. A termination that arrives together with a completion is not reported as a fault.

Top module: `dmairq_bank`

## Requirements
- R1: After reset, all three registers read 0, and `irq`, `fault`, `chan_freeze` and `chan_reset` are all 0.
- R2: The register index is `bus_addr[5:2]`. Index 1 (word 4) is the completion register: bits [15:0] are completion status and bits [31:16] are interrupt enables. Index 2 (word 8) is the error register: bits [15:0] are error flags and bits [31:16] are bus-error status. Index 3 (word 12) is the channel control register: bits [15:0] freeze channels and bits [31:16] reset channels. Any other index reads 0 and ignores writes.
- R3: `bus_addr[1:0]` selects the write view. 0 replaces the register, 1 sets the bits written as 1, and 2 clears the bits written as 1. 3 leaves the register unchanged. Bits written as 0 through views 1 and 2 keep their value. All four views read the register value.
- R4: A pulse on `ev_done[i]` sets completion bit i on the next clock edge. The bit stays set until software clears it.
- R5: A pulse on `ev_term[i]` sets only error flag i. A pulse on `ev_buserr[i]` sets error flag i and bus-error status bit 16+i.
- R6: When an event and a software write that would clear the same bit land in the same cycle, the bit ends up set.
- R7: `irq[i]` is high while completion bit i and enable bit 16+i are both set, or while error flag i is set. It stays high with no bus write.
- R8: `fault[i]` is high while bus-error status i is set, or while error flag i is set and completion bit i is clear. A termination together with a completion gives no fault.
- R9: `chan_freeze` equals bits [15:0] of the channel control register.
- R10: Writing 1 to control bit 16+i makes `chan_reset[i]` high for exactly one cycle after the write edge. The bit then clears itself and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address: register index in [5:2], write view in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_done | input | 16 | Per-channel completion pulse |
| ev_term | input | 16 | Per-channel termination pulse |
| ev_buserr | input | 16 | Per-channel bus-error pulse |
| irq | output | 16 | Per-channel interrupt |
| fault | output | 16 | Per-channel fault indication |
| chan_freeze | output | 16 | Per-channel pause control |
| chan_reset | output | 16 | Per-channel one-cycle reset pulse |

## Verification
The assertions on interrupt stickiness, freeze stability and the reset pulse apply only to cycles in which no bus write is made. They also expect events to arrive as pulses that the bank may see on any cycle. The bench's write task always returns the bus to idle for at least one cycle, so those properties are exercised after every write. The bench sweeps every channel alone, then several channels at once. The only cycle it places an event on top of a clearing write is the deliberate R6 case.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLEAR = 2'd2,
    VIEW_NONE  = 2'd3
  } view_e;

  localparam int IDX_DONE = 1;
  localparam int IDX_ERR  = 2;
  localparam int IDX_CTL  = 3;

endpackage

// File: rtl/dmairq_alias_reg.sv
module dmairq_alias_reg
  import dmairq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wen,
  input  view_e        sw_view,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Order: self-clear, then software view, then hardware set (events win).
  always_comb begin
    nxt = q & ~hw_clr;
    if (sw_wen) begin
      unique case (sw_view)
        VIEW_PLAIN: nxt = sw_data;
        VIEW_SET:   nxt = nxt | sw_data;
        VIEW_CLEAR: nxt = nxt & ~sw_data;
        default:    nxt = nxt;
      endcase
    end
    nxt = nxt | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R4 R5 R6: every hardware event bit is present after the edge.
  assert_hw_event_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/dmairq_chan_out.sv
module dmairq_chan_out #(
  parameter int NCH = 16,
  localparam int DW = 2 * NCH
) (
  input  logic [DW-1:0]  done_q,
  input  logic [DW-1:0]  err_q,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] fault
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cmp_hit;
    logic err_flag;
    logic bus_stat;
    assign cmp_hit  = done_q[i] & done_q[NCH+i];
    assign err_flag = err_q[i];
    assign bus_stat = err_q[NCH+i];
    assign irq[i]   = cmp_hit | err_flag;
    // Termination alongside completion is benign; bus error never is.
    assign fault[i] = bus_stat | (err_flag & ~done_q[i]);
  end

endmodule

// File: rtl/dmairq_bank.sv
module dmairq_bank
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 6,
  localparam int DW    = 2 * NCH,
  localparam int IW    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    ev_done,
  input  logic [NCH-1:0]    ev_term,
  input  logic [NCH-1:0]    ev_buserr,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    fault,
  output logic [NCH-1:0]    chan_freeze,
  output logic [NCH-1:0]    chan_reset
);

  logic [IW-1:0] idx;
  view_e         view;
  logic          wen_done, wen_err, wen_ctl;
  logic [DW-1:0] done_q, err_q, ctl_q;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign view     = view_e'(bus_addr[1:0]);
  assign wen_done = bus_wen && (idx == IW'(IDX_DONE));
  assign wen_err  = bus_wen && (idx == IW'(IDX_ERR));
  assign wen_ctl  = bus_wen && (idx == IW'(IDX_CTL));

  dmairq_alias_reg #(.W(DW)) u_done_reg (
    .clk(clk), .rst_n(rst_n),
    .sw_wen(wen_done), .sw_view(view), .sw_data(bus_wdata),
    .hw_set({{NCH{1'b0}}, ev_done}),
    .hw_clr('0),
    .q(done_q)
  );

  dmairq_alias_reg #(.W(DW)) u_err_reg (
    .clk(clk), .rst_n(rst_n),
    .sw_wen(wen_err), .sw_view(view), .sw_data(bus_wdata),
    .hw_set({ev_buserr, ev_term | ev_buserr}),
    .hw_clr('0),
    .q(err_q)
  );

  dmairq_alias_reg #(.W(DW)) u_ctl_reg (
    .clk(clk), .rst_n(rst_n),
    .sw_wen(wen_ctl), .sw_view(view), .sw_data(bus_wdata),
    .hw_set('0),
    .hw_clr({ctl_q[DW-1:NCH], {NCH{1'b0}}}),
    .q(ctl_q)
  );

  dmairq_chan_out #(.NCH(NCH)) u_out (
    .done_q(done_q), .err_q(err_q), .irq(irq), .fault(fault)
  );

  assign chan_freeze = ctl_q[NCH-1:0];
  assign chan_reset  = ctl_q[DW-1:NCH];

  always_comb begin
    if      (idx == IW'(IDX_DONE)) bus_rdata = done_q;
    else if (idx == IW'(IDX_ERR))  bus_rdata = err_q;
    else if (idx == IW'(IDX_CTL))  bus_rdata = ctl_q;
    else                           bus_rdata = '0;
  end

  // R7: with the bus idle, no asserted interrupt drops.
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> ((irq & $past(irq)) == $past(irq)));

  // R9: freeze only moves on a bus write.
  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> $stable(chan_freeze));

  // R10: a reset pulse lasts one cycle unless rewritten.
  assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_reset != '0) && !bus_wen) |=> (chan_reset == '0));

  // R5 R8: a bus error always yields a fault on that channel.
  assert_buserr_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buserr != '0) |=> ((fault & $past(ev_buserr)) == $past(ev_buserr)));

endmodule

// File: tb/dmairq_bank_tb.sv
module dmairq_bank_tb;
  localparam int CLK_P = 10;
  localparam int NCH = 16;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wen = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] ev_done = '0, ev_term = '0, ev_buserr = '0;
  logic [NCH-1:0] irq, fault, chan_freeze, chan_reset;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dmairq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
    .ev_term(ev_term), .ev_buserr(ev_buserr), .irq(irq), .fault(fault),
    .chan_freeze(chan_freeze), .chan_reset(chan_reset)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] tm, input logic [NCH-1:0] be);
    @(negedge clk);
    ev_done = dn; ev_term = tm; ev_buserr = be;
    @(negedge clk);
    ev_done = '0; ev_term = '0; ev_buserr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'd4, v);  chk("R1 done reg", v, '0);
    rd(6'd8, v);  chk("R1 err reg", v, '0);
    rd(6'd12, v); chk("R1 ctl reg", v, '0);
    chk("R1 outputs", {irq, fault}, '0);
    chk("R1 ctl outputs", {chan_freeze, chan_reset}, '0);

    // R3 set view accumulates enables one by one
    exp = '0;
    for (int i = 0; i < NCH; i++) begin
      wr(6'd5, 32'h1 << (16 + i));
      exp = exp | (32'h1 << (16 + i));
      rd(6'd4, v); chk("R3 set view", v, exp);
    end
    // R3 clear view removes even enables only
    for (int i = 0; i < NCH; i += 2) begin
      wr(6'd6, 32'h1 << (16 + i));
      exp = exp & ~(32'h1 << (16 + i));
    end
    rd(6'd4, v); chk("R3 clear view", v, exp);
    rd(6'd5, v); chk("R3 read via set view", v, exp);
    // R3 view 3 ignored
    wr(6'd7, 32'h0000_1234); rd(6'd4, v); chk("R3 view3 ignored", v, exp);
    // R3 plain write replaces
    wr(6'd4, 32'hFFFF_0000); rd(6'd4, v); chk("R3 plain write", v, 32'hFFFF_0000);
    // R2 unmapped index
    wr(6'd0, 32'hDEAD_BEEF); rd(6'd0, v); chk("R2 unmapped idx0", v, '0);
    wr(6'd16, 32'hDEAD_BEEF); rd(6'd16, v); chk("R2 unmapped idx4", v, '0);
    rd(6'd4, v); chk("R2 no alias write", v, 32'hFFFF_0000);

    // R4 R7 per-channel completion, enables all on
    for (int i = 0; i < NCH; i++) begin
      evt(16'h1 << i, '0, '0);
      rd(6'd4, v); chk("R4 done bit", v, 32'hFFFF_0000 | (32'h1 << i));
      chk("R7 irq done", {16'h0, irq}, 32'h1 << i);
      chk("R8 no fault on done", {16'h0, fault}, '0);
      @(negedge clk);
      chk("R4 sticky", {16'h0, irq}, 32'h1 << i);
      wr(6'd6, 32'h1 << i);
      chk("R7 irq cleared", {16'h0, irq}, '0);
    end
    // R7 enable mask applied on a multi-channel burst
    wr(6'd4, 32'hAAAA_0000);
    evt(16'hFFFF, '0, '0);
    chk("R7 masked irq", {16'h0, irq}, 32'h0000_AAAA);
    rd(6'd4, v); chk("R4 all done", v, 32'hAAAA_FFFF);
    wr(6'd4, 32'hFFFF_0000);

    // R5 R8 termination and bus error per channel
    for (int i = 0; i < NCH; i++) begin
      evt('0, 16'h1 << i, '0);
      rd(6'd8, v); chk("R5 term flag", v, 32'h1 << i);
      chk("R7 irq err", {16'h0, irq}, 32'h1 << i);
      chk("R8 term fault", {16'h0, fault}, 32'h1 << i);
      evt(16'h1 << i, '0, '0);
      chk("R8 term with done", {16'h0, fault}, '0);
      wr(6'd10, 32'h1 << i);
      evt('0, '0, 16'h1 << i);
      rd(6'd8, v); chk("R5 buserr halves", v, (32'h1 << i) | (32'h1 << (16 + i)));
      chk("R8 buserr fault with done", {16'h0, fault}, 32'h1 << i);
      wr(6'd8, '0);
      wr(6'd6, 32'h1 << i);
      chk("R8 all clear", {irq, fault}, '0);
    end

    // R6 event beats simultaneous clear
    @(negedge clk);
    ev_done = 16'h0008; bus_wen = 1'b1; bus_addr = 6'd6; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    ev_done = '0; bus_wen = 1'b0;
    rd(6'd4, v); chk("R6 event wins", v, 32'hFFFF_0008);
    wr(6'd6, 32'h0000_0008);

    // R9 freeze
    wr(6'd12, 32'h0000_5A5A); chk("R9 freeze plain", {16'h0, chan_freeze}, 32'h5A5A);
    wr(6'd13, 32'h0000_0101); chk("R9 freeze set", {16'h0, chan_freeze}, 32'h5B5B);
    wr(6'd14, 32'h0000_5000); chk("R9 freeze clear", {16'h0, chan_freeze}, 32'h0B5B);
    chk("R9 no reset from low write", {16'h0, chan_reset}, '0);
    wr(6'd12, '0);

    // R10 reset pulses
    for (int i = 0; i < NCH; i++) begin
      wr(6'd13, 32'h1 << (16 + i));
      chk("R10 pulse high", {16'h0, chan_reset}, 32'h1 << i);
      @(negedge clk);
      chk("R10 pulse gone", {16'h0, chan_reset}, '0);
      rd(6'd12, v); chk("R10 reads 0", v, '0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule